// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Triggers

This block gives software control of up to 32 general-purpose pins through a small word-addressed register bus. Each pin is either an output, driving a stored value bit, or an input. Input pins are brought into the clock domain through a two-stage synchronizer. Their synchronized level and transitions are then compared against a per-pin trigger setting. That setting selects level or edge sensitivity, a polarity, and an optional mode in which either transition triggers.

Trigger events latch into a raw status register. The raw status register stays set until software clears bits by writing ones to an acknowledge address. A per-pin enable mask turns raw status into pending status. A single registered interrupt line is the OR of all pending bits. Masking every pin and restoring the mask later loses no latched event. A read-only revision word tells software whether the both-transitions mode is built in. The revision word reads 3 when it is present and 2 when it is not.

Register words sit at byte offsets that software depends on:

| Offset | Register |
|---|---|
| 0x00 | pin level |
| 0x04 | direction |
| 0x08 | interrupt enable |
| 0x0C | raw status |
| 0x10 | pending |
| 0x14 | acknowledge |
| 0x18 | trigger kind |
| 0x1C | polarity |
| 0x20 | revision |
| 0x24 | both-transitions |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero except the revision word at 0x20, which reads 3; pin_out is zero, pin_oe is all ones, and irq is low.
- R2: A direction bit (0x04) of 0 makes the pin an output: pin_oe bit is 1 and pin_out bit follows the stored level bit written at 0x00; a direction bit of 1 clears pin_oe. A read of 0x00 returns the synchronized input for input pins and the stored bit for output pins.
- R3: With trigger kind bit (0x18) at 0, an input pin latches its raw status bit (0x0C) while its synchronized level equals its polarity bit (0x1C): 1 means active-high, 0 active-low.
- R4: With trigger kind bit 1 and both-transitions bit (0x24) 0, an input pin latches status only on a rising transition when polarity is 1, or on a falling transition when polarity is 0. A pin held steady after an edge does not latch again.
- R5: With trigger kind bit 1 and both-transitions bit 1, either transition latches status. The both-transitions register reads back what was written.
- R6: Writing a mask to 0x14 clears raw status bits where the mask is 1 and leaves bits where it is 0; a 0x14 read returns zero.
- R7: Pending (0x10) equals raw status AND enable (0x08); irq goes high one cycle after any pending bit is set. Writing the enable to zero drops irq without clearing raw status, and restoring it raises irq again.
- R8: A pin whose direction bit is 0 never latches status, whatever its input does.
- R9: An input change applied between clock edges reaches raw status on the third rising edge and irq on the fourth.
- R10: Writes to raw status, pending and revision have no effect. Reads of undefined or misaligned addresses return zero.
- R11: A level-sensitive pin still at its active level shows its status bit set right after it is acknowledged; once inactive, an acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data valid the next cycle |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables, 1 = drive |
| irq | output | 1 | Combined interrupt line |

## Verification
The assertions watch, on every cycle, the behaviours that have fixed local timing:
- the synchronizer pipeline delay;
- acknowledge clearing only the masked bits while unmasked raw bits persist;
- irq tracking pending one cycle later;
- output-enable following direction writes;
- no raw bit ever rising on a pin that was an output.

Only the bench scenarios can show the trigger semantics end to end, because each depends on a sequence of pin changes and configuration writes. These cover:
- level polarity;
- single and double edge selection;
- level re-latching after acknowledge;
- mask-and-restore;
- ignored writes to read-only words.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Word index decoded from byte address bits [5:2]
  localparam logic [3:0] IDX_LEVEL = 4'd0;
  localparam logic [3:0] IDX_DIRN  = 4'd1;
  localparam logic [3:0] IDX_IEN   = 4'd2;
  localparam logic [3:0] IDX_RAW   = 4'd3;
  localparam logic [3:0] IDX_PEND  = 4'd4;
  localparam logic [3:0] IDX_ACK   = 4'd5;
  localparam logic [3:0] IDX_KIND  = 4'd6;
  localparam logic [3:0] IDX_POL   = 4'd7;
  localparam logic [3:0] IDX_REV   = 4'd8;
  localparam logic [3:0] IDX_ANY   = 4'd9;
  localparam logic [3:0] IDX_LAST  = IDX_ANY;

  localparam logic [31:0] REV_WITH_ANY = 32'd3;
  localparam logic [31:0] REV_NO_ANY   = 32'd2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] cur_q,
  output logic [WIDTH-1:0] prev_q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  // Checker state: edges seen since reset, saturating
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)               warm_q <= 2'd0;
    else if (warm_q != 3)  warm_q <= warm_q + 2'd1;
  end

  assert_sync_delay_R9: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3) |-> (cur_q == $past(async_in, 2)));

  assert_prev_delay_R9: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3) |-> (prev_q == $past(cur_q)));
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0] cur,
  input  logic [NPINS-1:0] prev,
  input  logic [NPINS-1:0] is_input,
  input  logic [NPINS-1:0] kind_edge,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] any_edge,
  output logic [NPINS-1:0] evt
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, hit;
    always_comb begin
      rise = cur[i] & ~prev[i];
      fall = ~cur[i] & prev[i];
      if (!kind_edge[i])     hit = (cur[i] == pol[i]);
      else if (any_edge[i])  hit = rise | fall;
      else if (pol[i])       hit = rise;
      else                   hit = fall;
      evt[i] = hit & is_input[i];
    end
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS        = 32,
  parameter bit          HAS_ANY_EDGE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [NPINS-1:0] wr_data,
  output logic [NPINS-1:0] level_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] oe_q,
  output logic [NPINS-1:0] ien_q,
  output logic [NPINS-1:0] kind_q,
  output logic [NPINS-1:0] pol_q,
  output logic [NPINS-1:0] any_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      dir_q   <= '0;
      oe_q    <= '1;
      ien_q   <= '0;
      kind_q  <= '0;
      pol_q   <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_LEVEL: level_q <= wr_data;
        IDX_DIRN: begin
          dir_q <= wr_data;
          oe_q  <= ~wr_data;
        end
        IDX_IEN:  ien_q  <= wr_data;
        IDX_KIND: kind_q <= wr_data;
        IDX_POL:  pol_q  <= wr_data;
        default: ;
      endcase
    end
  end

  if (HAS_ANY_EDGE) begin : g_any
    always_ff @(posedge clk) begin
      if (rst)                                any_q <= '0;
      else if (wr_en && wr_idx == IDX_ANY)    any_q <= wr_data;
    end
  end else begin : g_no_any
    assign any_q = '0;
  end

  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_DIRN) |=> (oe_q == ~$past(wr_data)));
endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_en,
  input  logic [NPINS-1:0] ack_mask,
  input  logic [NPINS-1:0] evt,
  input  logic [NPINS-1:0] ien,
  output logic [NPINS-1:0] raw_q,
  output logic [NPINS-1:0] pend,
  output logic             irq_q
);
  logic [NPINS-1:0] ack_eff;
  assign ack_eff = ack_en ? ack_mask : '0;
  assign pend    = raw_q & ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      irq_q <= 1'b0;
    end else begin
      // A fresh event wins over an acknowledge in the same cycle
      raw_q <= (raw_q & ~ack_eff) | evt;
      irq_q <= |pend;
    end
  end

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    ack_en |=> ((raw_q & $past(ack_mask & ~evt)) == '0));

  assert_unacked_kept_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(raw_q & ~ack_eff)) == $past(raw_q & ~ack_eff)));

  assert_irq_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == $past(|pend)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS        = 32,
  parameter int unsigned ADDR_W       = 8,
  parameter bit          HAS_ANY_EDGE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam logic [31:0] REV_WORD = HAS_ANY_EDGE ? REV_WITH_ANY : REV_NO_ANY;

  function automatic logic [31:0] widen(input logic [NPINS-1:0] v);
    logic [31:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  // Address decode: aligned, within the ten-word window
  logic [3:0] idx;
  logic       hit;
  assign idx = bus_addr[5:2];
  assign hit = (bus_addr[ADDR_W-1:6] == '0) && (bus_addr[1:0] == 2'b00)
               && (idx <= IDX_LAST);

  logic wr_ok;
  assign wr_ok = bus_wr && hit;

  logic [NPINS-1:0] level_q, dir_q, oe_q, ien_q, kind_q, pol_q, any_q;
  logic [NPINS-1:0] cur, prev, evt, raw_q, pend;
  logic             irq_q;

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .cur_q    (cur),
    .prev_q   (prev)
  );

  gpio_cfg_regs #(.NPINS(NPINS), .HAS_ANY_EDGE(HAS_ANY_EDGE)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ok),
    .wr_idx  (idx),
    .wr_data (bus_wdata[NPINS-1:0]),
    .level_q (level_q),
    .dir_q   (dir_q),
    .oe_q    (oe_q),
    .ien_q   (ien_q),
    .kind_q  (kind_q),
    .pol_q   (pol_q),
    .any_q   (any_q)
  );

  gpio_trig_detect #(.NPINS(NPINS)) u_trig (
    .cur       (cur),
    .prev      (prev),
    .is_input  (dir_q),
    .kind_edge (kind_q),
    .pol       (pol_q),
    .any_edge  (any_q),
    .evt       (evt)
  );

  gpio_irq_latch #(.NPINS(NPINS)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .ack_en   (wr_ok && idx == IDX_ACK),
    .ack_mask (bus_wdata[NPINS-1:0]),
    .evt      (evt),
    .ien      (ien_q),
    .raw_q    (raw_q),
    .pend     (pend),
    .irq_q    (irq_q)
  );

  assign pin_out = level_q;
  assign pin_oe  = oe_q;
  assign irq     = irq_q;

  // Registered read-back
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (hit) begin
        case (idx)
          IDX_LEVEL: bus_rdata <= widen((dir_q & cur) | (~dir_q & level_q));
          IDX_DIRN:  bus_rdata <= widen(dir_q);
          IDX_IEN:   bus_rdata <= widen(ien_q);
          IDX_RAW:   bus_rdata <= widen(raw_q);
          IDX_PEND:  bus_rdata <= widen(pend);
          IDX_KIND:  bus_rdata <= widen(kind_q);
          IDX_POL:   bus_rdata <= widen(pol_q);
          IDX_REV:   bus_rdata <= REV_WORD;
          IDX_ANY:   bus_rdata <= widen(any_q);
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  // A raw bit may only rise on a pin that was an input in the cycle before
  assert_output_pin_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((raw_q & ~$past(raw_q)) & ~$past(dir_q)) == '0));
endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  localparam logic [7:0] A_LEVEL = 8'h00, A_DIRN = 8'h04, A_IEN = 8'h08,
                         A_RAW = 8'h0C, A_PEND = 8'h10, A_ACK = 8'h14,
                         A_KIND = 8'h18, A_POL = 8'h1C, A_REV = 8'h20,
                         A_ANY = 8'h24;

  // Scoreboard of expected read data
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: read data with no expected item");
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%08h expected=%08h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", t, act, e);
    end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    chk(pin_out, 32'h0, "R1 pin_out");
    chk(pin_oe, 32'hFFFF_FFFF, "R1 pin_oe");
    chk({31'b0, irq}, 32'h0, "R1 irq");
    rd(A_LEVEL, 32'h0, "R1 level");
    rd(A_DIRN, 32'h0, "R1 dirn");
    rd(A_IEN, 32'h0, "R1 ien");
    rd(A_RAW, 32'h0, "R1 raw");
    rd(A_PEND, 32'h0, "R1 pend");
    rd(A_KIND, 32'h0, "R1 kind");
    rd(A_POL, 32'h0, "R1 pol");
    rd(A_ANY, 32'h0, "R1 any");
    rd(A_REV, 32'h3, "R1 rev");

    // R2 direction and output values
    wr(A_POL, 32'hFFFF_FFFF);
    wr(A_DIRN, 32'h0000_FFF0);
    wr(A_LEVEL, 32'hA5A5_0003);
    tick(1);
    chk(pin_out, 32'hA5A5_0003, "R2 pin_out");
    chk(pin_oe, 32'hFFFF_000F, "R2 pin_oe");
    pin_in = 32'h0000_8004;
    tick(4);
    rd(A_LEVEL, 32'hA5A5_8003, "R2 level mix");
    pin_in = 32'h0;
    tick(4);
    wr(A_ACK, 32'hFFFF_FFFF);
    tick(1);
    rd(A_RAW, 32'h0, "R6 clear all");

    // R3 active-high level, R7 pending/irq, R11 re-latch
    pin_in[4] = 1'b1;
    tick(4);
    rd(A_RAW, 32'h10, "R3 level high");
    chk({31'b0, irq}, 32'h0, "R7 irq masked");
    rd(A_PEND, 32'h0, "R7 pend masked");
    wr(A_IEN, 32'h10);
    tick(3);
    chk({31'b0, irq}, 32'h1, "R7 irq enabled");
    rd(A_PEND, 32'h10, "R7 pend");
    wr(A_ACK, 32'h10);
    tick(2);
    rd(A_RAW, 32'h10, "R11 still active");
    pin_in[4] = 1'b0;
    tick(4);
    wr(A_ACK, 32'h10);
    tick(2);
    rd(A_RAW, 32'h0, "R11 inactive cleared");
    chk({31'b0, irq}, 32'h0, "R7 irq low");

    // R3 active-low level on pin 5
    wr(A_POL, 32'hFFFF_FFDF);
    tick(2);
    rd(A_RAW, 32'h20, "R3 level low");
    pin_in[5] = 1'b1;
    tick(4);
    wr(A_ACK, 32'h20);
    tick(2);
    rd(A_RAW, 32'h0, "R3 level low inactive");

    // R4 single edges: pin 6 rising, pin 7 falling
    wr(A_KIND, 32'h0000_00C0);
    wr(A_POL, 32'hFFFF_FF5F);
    tick(4);
    rd(A_RAW, 32'h0, "R4 no edge yet");
    pin_in[7:6] = 2'b11;
    tick(4);
    rd(A_RAW, 32'h40, "R4 rising");
    wr(A_ACK, 32'h40);
    tick(4);
    rd(A_RAW, 32'h0, "R4 held high no relatch");
    pin_in[7:6] = 2'b00;
    tick(4);
    rd(A_RAW, 32'h80, "R4 falling");
    wr(A_ACK, 32'hFFFF_FFFF);

    // R5 both transitions on pin 8
    wr(A_KIND, 32'h0000_01C0);
    wr(A_ANY, 32'h0000_0100);
    rd(A_ANY, 32'h100, "R5 readback");
    pin_in[8] = 1'b1;
    tick(4);
    rd(A_RAW, 32'h100, "R5 rise");
    wr(A_ACK, 32'h100);
    tick(4);
    rd(A_RAW, 32'h0, "R5 cleared");
    pin_in[8] = 1'b0;
    tick(4);
    rd(A_RAW, 32'h100, "R5 fall");

    // R6 selective acknowledge
    pin_in[6] = 1'b1;
    tick(4);
    rd(A_RAW, 32'h140, "R6 two set");
    wr(A_ACK, 32'h40);
    tick(2);
    rd(A_RAW, 32'h100, "R6 mask bit only");
    wr(A_ACK, 32'h0);
    tick(2);
    rd(A_RAW, 32'h100, "R6 zero mask");
    rd(A_ACK, 32'h0, "R6 ack reads zero");

    // R7 mask and restore
    wr(A_IEN, 32'h100);
    tick(3);
    chk({31'b0, irq}, 32'h1, "R7 irq on");
    wr(A_IEN, 32'h0);
    tick(3);
    chk({31'b0, irq}, 32'h0, "R7 irq masked off");
    rd(A_RAW, 32'h100, "R7 raw kept");
    wr(A_IEN, 32'h100);
    tick(3);
    chk({31'b0, irq}, 32'h1, "R7 irq restored");
    wr(A_ACK, 32'hFFFF_FFFF);
    tick(3);
    chk({31'b0, irq}, 32'h0, "R7 irq after ack");

    // R8 output pin 0 configured for edges is ignored
    wr(A_KIND, 32'h0000_01C1);
    pin_in[0] = 1'b1;
    tick(4);
    pin_in[0] = 1'b0;
    tick(4);
    rd(A_RAW, 32'h0, "R8 output pin quiet");
    chk(pin_out, 32'hA5A5_0003, "R8 pin_out unchanged");

    // R9 latency: pin 6 rising edge to irq
    pin_in[6] = 1'b0;
    wr(A_IEN, 32'h40);
    tick(4);
    wr(A_ACK, 32'hFFFF_FFFF);
    tick(3);
    pin_in[6] = 1'b1;
    tick(3);
    chk({31'b0, irq}, 32'h0, "R9 irq not before fourth edge");
    tick(1);
    chk({31'b0, irq}, 32'h1, "R9 irq at fourth edge");

    // R10 read-only words and undefined addresses
    wr(A_REV, 32'hFFFF_FFFF);
    wr(A_RAW, 32'hFFFF_FFFF);
    wr(A_PEND, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(A_REV, 32'h3, "R10 rev unchanged");
    rd(A_RAW, 32'h40, "R10 raw unchanged");
    rd(A_PEND, 32'h40, "R10 pend unchanged");
    rd(8'h28, 32'h0, "R10 undefined word");
    rd(8'h40, 32'h0, "R10 outside window");
    rd(8'h01, 32'h0, "R10 misaligned");
    rd(A_DIRN, 32'h0000_FFF0, "R10 dirn intact");

    tick(3);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: %0d reads never returned (expected 0)", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete (expected completion)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule